// File: doc/BRIEF.md
# Queued SPI Master Sequencer Control

This block is the control core of a queued SPI master. It walks a current pointer through a 16-entry queue of transfer slots, from a start pointer to an end pointer. For each slot it issues a start strobe to an external shifter and waits for that shifter's done strobe. When the done strobe arrives it raises a receive-write strobe addressed at the slot, then moves on. At the end of the list it either finishes or, in wrap mode, begins another pass at the start pointer. Each new pass writes over the receive results of the earlier pass.

Software drives the block through three registers on a small read/write bus. Software can stop the sequencer in two ways. A halt request lets the transfer in flight complete before the sequencer stops. Clearing the enable bit stops it at once and aborts the transfer in flight. A multi-master conflict is detected from a synchronized slave-select input. It shuts the sequencer down and hands the serial pins back to the general-purpose port. The resulting fault flag can only be cleared by a status read that saw it set, followed by a status write.

Register map (2-bit address):
- 0 control: bit0 enable, bit1 wrap, bit2 halt, bit3 fault interrupt enable, bit4 master, bit5 slave-select pin is output.
- 1 pointers: [3:0] start, [7:4] end, [11:8] current (read-only).
- 2 status: bit0 finished, bit1 mode fault.
- 3 reads zero.

Top module: `qspi_seq_ctrl`

## Requirements
- R1: With wrap set, a done strobe on the end slot is followed by a transfer of the start slot, and enable stays 1.
- R2: Every done strobe seen while running produces a one-cycle rx_we_o with rx_addr_o equal to the current slot. A later wrap pass strobes the same slot addresses again.
- R3: With wrap clear, the done strobe on the end slot sets status bit0, clears control bit0, and no further start strobe follows.
- R4: While halt is set, the transfer in flight completes (it gets its receive strobe) and no new start strobe is issued. Clearing halt resumes at the following slot. Clearing enable while halted produces no abort.
- R5: Clearing enable during a transfer pulses xfer_abort_o for exactly the next cycle. The aborted slot gets no receive strobe and no start follows.
- R6: The mode fault (status bit1) is set when master is 1, the select pin is an input (control bit5 = 0), and ss_pin_i has been low through the two synchronizer flops. The flag is visible on the third rising edge after the pin falls.
- R7: On a mode fault, control bit0 is cleared and pin_own_o drops to 0.
- R8: irq_o is 1 exactly when the fault flag and control bit3 are both 1.
- R9: A status write with bit1 = 0 clears the fault flag only if a status read that returned bit1 = 1 came before it. Without such a read, the write leaves the flag set.
- R10: No fault is raised while control bit5 = 1 or master = 0, whatever ss_pin_i does.
- R11: After reset, all registers read 0 and irq_o, xfer_start_o, pin_own_o are 0.
- R12: A run visits slots from start to end, incrementing modulo 16, one transfer at a time. The current pointer is readable in pointer bits [11:8]. A status write with bit0 = 0 clears the finished flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| irq_o | output | 1 | Mode-fault interrupt request |
| xfer_start_o | output | 1 | Start strobe to the shifter |
| xfer_abort_o | output | 1 | Abort strobe to the shifter |
| xfer_done_i | input | 1 | Done strobe from the shifter |
| rx_we_o | output | 1 | Receive-slot write strobe |
| rx_addr_o | output | 4 | Receive-slot address |
| ss_pin_i | input | 1 | Slave-select pin, asynchronous |
| pin_own_o | output | 1 | 1: sequencer drives the serial pins; 0: port data register does |

## Verification
Each result has its own due cycle:
- A register write takes effect on the rising edge that captures it.
- The first start strobe appears in the cycle after enable becomes 1.
- The receive strobe appears in the same cycle as the done strobe.
- The abort strobe appears in the cycle right after enable is cleared.
- The fault flag and irq_o appear on the third rising edge after ss_pin_i falls.

The bench drives all inputs on falling edges and samples 1 ns after a falling edge. It checks irq_o both one cycle before and on the cycle the fault is due. It counts start, receive and abort strobes as they occur, so a halt or an abort can be confirmed by counts that stay frozen over a long window.

// File: rtl/qspi_seq_pkg.sv
`timescale 1ns/1ps
package qspi_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_BUSY, SQ_HALT} sq_state_e;

  // control field order matches register bits 5..0
  typedef struct packed {
    logic ss_out;
    logic master;
    logic fault_ie;
    logic halt;
    logic wrap;
    logic en;
  } ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PTR  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam int S_FIN = 0;
  localparam int S_FLT = 1;
endpackage

// File: rtl/qspi_ss_sync.sv
`timescale 1ns/1ps
module qspi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ss_pin_i,
  output logic ss_low_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= ss_pin_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign ss_low_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/qspi_seq_regs.sv
`timescale 1ns/1ps
module qspi_seq_regs
  import qspi_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ss_low_i,
  input  logic              fin_evt_i,
  input  logic [PTR_W-1:0]  cur_ptr_i,
  output ctrl_t             ctrl_o,
  output logic [PTR_W-1:0]  start_ptr_o,
  output logic [PTR_W-1:0]  end_ptr_o,
  output logic              fin_o,
  output logic              fault_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [PTR_W-1:0] start_q, end_q;
  logic             fin_q, fault_q, rd_seen_q;
  logic             wr_ctrl, wr_ptr, wr_stat, rd_stat, fault_set;

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_ptr    = reg_we_i && (reg_addr_i == A_PTR);
  assign wr_stat   = reg_we_i && (reg_addr_i == A_STAT);
  assign rd_stat   = reg_re_i && (reg_addr_i == A_STAT);
  assign fault_set = ctrl_q.master && !ctrl_q.ss_out && ss_low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      if (fin_evt_i || fault_set) ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (wr_ptr) begin
      start_q <= reg_wdata_i[PTR_W-1:0];
      end_q   <= reg_wdata_i[2*PTR_W-1:PTR_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q     <= 1'b0;
      fault_q   <= 1'b0;
      rd_seen_q <= 1'b0;
    end else begin
      if (wr_stat && !reg_wdata_i[S_FIN]) fin_q <= 1'b0;
      if (fin_evt_i) fin_q <= 1'b1;
      // two-step clear: qualifying read arms, next status write consumes
      if (wr_stat) rd_seen_q <= 1'b0;
      else if (rd_stat && fault_q) rd_seen_q <= 1'b1;
      if (wr_stat && rd_seen_q && !reg_wdata_i[S_FLT]) fault_q <= 1'b0;
      if (fault_set) fault_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
      A_PTR: begin
        reg_rdata_o[PTR_W-1:0]         = start_q;
        reg_rdata_o[2*PTR_W-1:PTR_W]   = end_q;
        reg_rdata_o[3*PTR_W-1:2*PTR_W] = cur_ptr_i;
      end
      A_STAT: begin
        reg_rdata_o[S_FIN] = fin_q;
        reg_rdata_o[S_FLT] = fault_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign start_ptr_o = start_q;
  assign end_ptr_o   = end_q;
  assign fin_o       = fin_q;
  assign fault_o     = fault_q;

  AST_FAULT_DROPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fault_q) |-> !ctrl_q.en); // R7
  AST_FAULT_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(fault_q) |-> $past(rd_seen_q)); // R9
  AST_FAULT_NEEDS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fault_q) |-> $past(ctrl_q.master && !ctrl_q.ss_out)); // R10
  AST_FIN_DROPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fin_q) |-> !ctrl_q.en); // R3
endmodule

// File: rtl/qspi_queue_fsm.sv
`timescale 1ns/1ps
module qspi_queue_fsm
  import qspi_seq_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wrap_i,
  input  logic             halt_i,
  input  logic [PTR_W-1:0] start_ptr_i,
  input  logic [PTR_W-1:0] end_ptr_i,
  input  logic             xfer_done_i,
  output logic             xfer_start_o,
  output logic             xfer_abort_o,
  output logic             rx_we_o,
  output logic [PTR_W-1:0] rx_addr_o,
  output logic [PTR_W-1:0] cur_ptr_o,
  output logic             fin_evt_o
);
  sq_state_e        state_q, state_d;
  logic [PTR_W-1:0] cur_q, cur_d;
  logic             at_end;

  assign at_end       = (cur_q == end_ptr_i);
  assign xfer_start_o = (state_q == SQ_ISSUE) && en_i;
  assign xfer_abort_o = (state_q == SQ_BUSY) && !en_i;
  assign rx_we_o      = (state_q == SQ_BUSY) && en_i && xfer_done_i;
  assign rx_addr_o    = cur_q;
  assign cur_ptr_o    = cur_q;
  assign fin_evt_o    = rx_we_o && at_end && !wrap_i;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    if (!en_i) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          cur_d   = start_ptr_i;
          state_d = SQ_ISSUE;
        end
        SQ_ISSUE: state_d = SQ_BUSY;
        SQ_BUSY: begin
          if (xfer_done_i) begin
            if (at_end && !wrap_i) begin
              state_d = SQ_IDLE;
            end else begin
              cur_d   = at_end ? start_ptr_i : cur_q + PTR_W'(1);
              state_d = halt_i ? SQ_HALT : SQ_ISSUE;
            end
          end
        end
        SQ_HALT: if (!halt_i) state_d = SQ_ISSUE;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) xfer_start_o |=> !xfer_start_o); // R12
  AST_ABORT_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) xfer_abort_o |=> (state_q == SQ_IDLE) && !xfer_abort_o); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) (rx_we_o && at_end && wrap_i) |=> (cur_q == $past(start_ptr_i))); // R1
  AST_HALT_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni) (rx_we_o && halt_i) |=> !xfer_start_o); // R4
  AST_FIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) fin_evt_o |=> (state_q == SQ_IDLE)); // R3
endmodule

// File: rtl/qspi_seq_ctrl.sv
`timescale 1ns/1ps
module qspi_seq_ctrl
  import qspi_seq_pkg::*;
#(
  parameter int QUEUE_DEPTH = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(QUEUE_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              xfer_start_o,
  output logic              xfer_abort_o,
  input  logic              xfer_done_i,
  output logic              rx_we_o,
  output logic [PTR_W-1:0]  rx_addr_o,
  input  logic              ss_pin_i,
  output logic              pin_own_o
);
  ctrl_t            ctrl;
  logic [PTR_W-1:0] start_ptr, end_ptr, cur_ptr;
  logic             ss_low, fin_evt, fin, fault;

  qspi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ss_pin_i (ss_pin_i),
    .ss_low_o (ss_low)
  );

  qspi_seq_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ss_low_i    (ss_low),
    .fin_evt_i   (fin_evt),
    .cur_ptr_i   (cur_ptr),
    .ctrl_o      (ctrl),
    .start_ptr_o (start_ptr),
    .end_ptr_o   (end_ptr),
    .fin_o       (fin),
    .fault_o     (fault)
  );

  qspi_queue_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctrl.en),
    .wrap_i       (ctrl.wrap),
    .halt_i       (ctrl.halt),
    .start_ptr_i  (start_ptr),
    .end_ptr_i    (end_ptr),
    .xfer_done_i  (xfer_done_i),
    .xfer_start_o (xfer_start_o),
    .xfer_abort_o (xfer_abort_o),
    .rx_we_o      (rx_we_o),
    .rx_addr_o    (rx_addr_o),
    .cur_ptr_o    (cur_ptr),
    .fin_evt_o    (fin_evt)
  );

  assign irq_o     = fault && ctrl.fault_ie;
  assign pin_own_o = ctrl.en && ctrl.master;

  AST_FAULT_RELEASES_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fault) |-> !pin_own_o); // R7
  AST_FIN_NO_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(fin) |-> !pin_own_o); // R3
endmodule

// File: tb/qspi_seq_ctrl_tb.sv
`timescale 1ns/1ps
module qspi_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, xstart, xabort, rx_we, pin_own;
  logic        xdone = 1'b0;
  logic        ss_pin = 1'b1;
  logic [3:0]  rx_addr;

  int n_chk = 0, n_fail = 0;
  int nlog = 0, nstart = 0, nabort = 0;
  int log_q [64];
  int stub_fix = 0;
  int stub_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  qspi_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .xfer_start_o(xstart),
    .xfer_abort_o(xabort), .xfer_done_i(xdone), .rx_we_o(rx_we), .rx_addr_o(rx_addr),
    .ss_pin_i(ss_pin), .pin_own_o(pin_own)
  );

  // stub shifter: done 1..4 cycles (or stub_fix) after start, cancelled by abort
  always @(negedge clk) begin
    xdone = 1'b0;
    if (xabort) stub_cnt = 0;
    else if (xstart) stub_cnt = (stub_fix != 0) ? stub_fix : int'($urandom_range(1, 4));
    else if (stub_cnt != 0) begin
      stub_cnt--;
      if (stub_cnt == 0) xdone = 1'b1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rx_we) begin log_q[nlog % 64] = int'(rx_addr); nlog++; end
    if (xstart) nstart++;
    if (xabort) nabort++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && pin_own; i++) @(negedge clk);
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 3000 && nlog < n; i++) @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int seq_at(input int s, input int e, input int i);
    int len = ((e - s) & 15) + 1;
    return (s + (i % len)) & 15;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog (run time): actual=expired expected=finished");
    summary();
  end

  initial begin
    logic [15:0] d;
    int s, e, n1, s1, a1, ok;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check(irq == 0 && xstart == 0 && pin_own == 0, "R11", "outputs after reset", {irq, xstart, pin_own}, 0);
    rd(2'd0, d); check(d == 0, "R11", "control after reset", d, 0);
    rd(2'd1, d); check(d == 0, "R11", "pointers after reset", d, 0);
    rd(2'd2, d); check(d == 0, "R11", "status after reset", d, 0);

    // R12 / R3: single pass 2..5
    wr(2'd1, 16'h0052);
    nlog = 0;
    wr(2'd0, 16'h0011);
    wait_idle();
    cycles(2);
    check(nlog == 4, "R12", "transfers in pass", nlog, 4);
    ok = 1; for (int i = 0; i < 4; i++) if (log_q[i] != 2 + i) ok = 0;
    check(ok == 1, "R2", "slot addresses 2..5", log_q[0], 2);
    rd(2'd2, d); check(d[0] == 1, "R3", "finished flag", d[0], 1);
    rd(2'd0, d); check(d[0] == 0, "R3", "enable cleared at end", d[0], 0);
    rd(2'd1, d); check(d[11:8] == 5, "R12", "current pointer at end", d[11:8], 5);
    wr(2'd2, 16'h0000);
    rd(2'd2, d); check(d[0] == 0, "R12", "finished flag cleared", d[0], 0);

    // R1 / R2: wrap 14..1 across slot 15
    wr(2'd1, 16'h001E);
    nlog = 0;
    wr(2'd0, 16'h0013);
    wait_log(10);
    #1;
    ok = 1; for (int i = 0; i < 10; i++) if (log_q[i] != seq_at(14, 1, i)) ok = 0;
    check(ok == 1, "R2", "wrap pass addresses repeat", log_q[4], 14);
    check(pin_own == 1, "R1", "enable held in wrap", pin_own, 1);
    wr(2'd0, 16'h0011);
    wait_idle();
    cycles(2);
    check(log_q[(nlog - 1) % 64] == 1, "R3", "stop on end slot after wrap clear", log_q[(nlog - 1) % 64], 1);
    rd(2'd2, d); check(d[0] == 1, "R3", "finished after wrap clear", d[0], 1);
    s1 = nstart; cycles(20);
    check(nstart == s1, "R3", "no start after finish", nstart, s1);
    wr(2'd2, 16'h0000);

    // R4: halt
    wr(2'd1, 16'h00F0);
    nlog = 0; nstart = 0; nabort = 0;
    wr(2'd0, 16'h0011);
    wait_log(3);
    wr(2'd0, 16'h0015);
    cycles(30);
    n1 = nlog; s1 = nstart;
    cycles(30);
    check(nlog == n1 && nstart == s1, "R4", "no activity while halted", nstart, s1);
    check(nstart == nlog && nabort == 0, "R4", "in-flight transfer completed", nlog, nstart);
    rd(2'd1, d); check(int'(d[11:8]) == n1, "R4", "pointer at next slot", d[11:8], n1);
    wr(2'd0, 16'h0011);
    wait_log(n1 + 1);
    #1;
    check(log_q[n1] == n1, "R4", "resume at following slot", log_q[n1], n1);
    wr(2'd0, 16'h0015);
    cycles(30);
    wr(2'd0, 16'h0014);
    cycles(3);
    check(nabort == 0, "R4", "enable clear while halted no abort", nabort, 0);
    wr(2'd0, 16'h0010);

    // R5: abort
    stub_fix = 40;
    wr(2'd1, 16'h0093);
    nlog = 0; nstart = 0; nabort = 0;
    wr(2'd0, 16'h0011);
    cycles(10);
    wr(2'd0, 16'h0010);
    #1;
    check(xabort == 1, "R5", "abort pulse", xabort, 1);
    cycles(1);
    check(xabort == 0, "R5", "abort one cycle", xabort, 0);
    cycles(60);
    check(nlog == 0 && nstart == 1 && nabort == 1, "R5", "no receive or restart after abort", nlog + nstart, 1);
    stub_fix = 0;

    // R6 / R7 / R8: mode fault
    wr(2'd1, 16'h00F0);
    wr(2'd0, 16'h0019);
    wait_log(nlog + 2);
    @(negedge clk); ss_pin = 1'b0;
    cycles(2);
    check(irq == 0 && pin_own == 1, "R6", "no fault before sync delay", irq, 0);
    cycles(1);
    check(irq == 1, "R8", "irq on fault", irq, 1);
    check(pin_own == 0, "R7", "pins released on fault", pin_own, 0);
    ss_pin = 1'b1;
    cycles(4);
    rd(2'd0, d); check(d[0] == 0, "R7", "enable cleared by fault", d[0], 0);
    wr(2'd2, 16'h0000);
    cycles(1);
    check(irq == 1, "R9", "write without read keeps fault", irq, 1);
    wr(2'd0, 16'h0010);
    cycles(1);
    check(irq == 0, "R8", "irq masked", irq, 0);
    wr(2'd0, 16'h0018);
    cycles(1);
    check(irq == 1, "R8", "irq unmasked", irq, 1);
    rd(2'd2, d); check(d[1] == 1, "R6", "fault flag read", d[1], 1);
    wr(2'd2, 16'h0000);
    cycles(1);
    check(irq == 0, "R9", "read then write clears", irq, 0);
    rd(2'd2, d); check(d[1] == 0, "R9", "fault flag cleared", d[1], 0);

    // R10: no fault with pin as output or not master
    nlog = 0;
    wr(2'd0, 16'h0031);
    @(negedge clk); ss_pin = 1'b0;
    cycles(10);
    check(pin_own == 1 && irq == 0, "R10", "pin as output ignores low", pin_own, 1);
    wr(2'd0, 16'h0001);
    cycles(10);
    rd(2'd2, d); check(d[1] == 0, "R10", "non-master ignores low", d[1], 0);
    wr(2'd0, 16'h0000);
    ss_pin = 1'b1;
    cycles(4);
    wr(2'd2, 16'h0000);

    // R12: random ranges
    for (int it = 0; it < 8; it++) begin
      s = int'($urandom_range(0, 15));
      e = int'($urandom_range(0, 15));
      wr(2'd1, 16'((e << 4) | s));
      nlog = 0;
      wr(2'd0, 16'h0011);
      wait_idle();
      cycles(2);
      a1 = ((e - s) & 15) + 1;
      ok = (nlog == a1);
      for (int i = 0; i < a1 && i < 64; i++) if (log_q[i] != seq_at(s, e, i)) ok = 0;
      check(ok == 1, "R12", "random range sequence length", nlog, a1);
      wr(2'd2, 16'h0000);
    end

    summary();
  end
endmodule